// File: doc/BRIEF.md
# Video Timing Reference Flywheel and Inserter

This block sits on a 10-bit multiplexed video word stream, one word per clock, and rewrites the timing reference sequences at each line boundary. Each line has two of them: one that ends active video (line position 0) and one that starts it (position `SAV_POS`). A flywheel tracks the position of every word within the line. It takes its timing either from an external horizontal strobe or from reference sequences detected in the incoming data. While it is locked, the block writes the four words of each reference sequence at the predicted positions. The last of those four words carries the field, vertical and horizontal flags and their protection bits.

The flywheel keeps predicting through a bounded run of missing or corrupted reference sequences before it gives up lock. A separate blanking control can force every word outside the reference slots to blanking levels. Insertion is gated by a global processing enable and a per-feature disable. The output is registered, so every word leaves the block exactly one clock after it enters.

Top module: `trs_flywheel_inserter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` becomes 000h. After reset the flywheel is unlocked, and every word passes through unchanged until the first timing event.
- R2: With `src_embedded` = 0 and `h_mode` = 0, the first word sampled with `h_in` low after a high word is taken as line position `SAV_POS`+4, which is the first active word. Position 0 follows position `LINE_LEN`-1.
- R3: With `src_embedded` = 0 and `h_mode` = 1, the first word sampled with `h_in` low after a high word is taken as line position `SAV_POS`. Here `h_in` follows the horizontal flag of the reference words.
- R4: When locked with insertion on, the words at positions 0..3 and `SAV_POS`..`SAV_POS`+3 become 3FFh, 000h, 000h and a flag word. The flag word, from bit 9 down to bit 0, is 1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0.
- R5: In external mode, F and V in the flag word are the values of `f_in` and `v_in` sampled with that word. H is 1 in the sequence at position 0 and 0 in the one at `SAV_POS`.
- R6: With `src_embedded` = 1, a run of 3FFh, 000h, 000h followed by a word whose protection bits match its F, V and H bits (bit 9 set, bits 1:0 clear) is a detected sequence. It sits at position 3 if its H bit is 1, otherwise at `SAV_POS`+3. Generated F and V come from the most recent detected sequence, and `v_in` and `f_in` have no effect.
- R7: In embedded mode, a missing or corrupted sequence at a predicted position counts as a miss, and a correct one clears the count. Up to `MISS_LIMIT` consecutive misses keep insertion going. The next miss drops lock after its own word, and no insertion happens until a new detected sequence re-locks.
- R8: Insertion happens only when `proc_en` is 1 and `trs_off` is 0. Otherwise the reference slot positions carry `din` unchanged.
- R9: When locked with `blank_n` = 0, every word outside the reference slots becomes 200h at even positions and 040h at odd positions. This requires `SAV_POS` to be even.
- R10: With `blank_n` = 1, every word outside an inserted reference slot appears on `dout` unchanged, one clock after it is on `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_embedded | input | 1 | 1: timing from detected reference sequences, 0: from external strobes |
| h_mode | input | 1 | External H meaning: 0 covers the whole blanking interval, 1 follows the reference H flag |
| h_in | input | 1 | External horizontal blanking strobe |
| v_in | input | 1 | External vertical blanking flag |
| f_in | input | 1 | External field flag (high in field 2) |
| proc_en | input | 1 | Global processing enable |
| trs_off | input | 1 | Per-feature disable for insertion |
| blank_n | input | 1 | 0 forces non-reference words to blanking levels |
| din | input | 10 | Input video word |
| dout | output | 10 | Output video word, one clock later |

## Verification
A wrong flywheel position shows as reference words landing at shifted positions. The first misplaced word reaches `dout` one clock after the word that was misclassified, within the first line after lock. A wrong lock or miss count shows as insertion that persists or stops one sequence too early or too late during a run of missing sequences. A wrong latched field or vertical flag shows in the very next generated flag word, even when the input sequence is absent.

// File: rtl/trs_fly_pkg.sv
// Shared constants and helpers for the timing reference flywheel.
// Assumes a 10-bit multiplexed word stream, one word per clock.
package trs_fly_pkg;
    localparam int WORD_W  = 10;
    localparam int TRS_LEN = 4;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t WORD_ONES = 10'h3FF;
    localparam word_t WORD_ZERO = 10'h000;
    localparam word_t BLANK_Y   = 10'h040;
    localparam word_t BLANK_C   = 10'h200;

    // Builds the flag word of a reference sequence with its protection bits.
    function automatic word_t xyz_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction
endpackage

// File: rtl/trs_embedded_detect.sv
// Finds complete reference sequences (3FF, 000, 000, valid flag word) in
// the input stream. Flags a hit on the cycle the flag word is present and
// reports its F, V and H bits. Assumes one word per clock.
module trs_embedded_detect
    import trs_fly_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t din,
    output logic  hit,
    output logic  hit_f,
    output logic  hit_v,
    output logic  hit_h
);
    localparam int HIST = TRS_LEN - 1;

    logic [HIST-1:0][WORD_W-1:0] hist;   // hist[0] is the previous word

    // Keeps the last three input words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[HIST-2:0], din};
        end
    end

    // Matches the header and checks the protection bits of the flag word.
    always_comb begin
        hit   = (hist[2] == WORD_ONES) && (hist[1] == WORD_ZERO) &&
                (hist[0] == WORD_ZERO) && (din == xyz_word(din[8], din[7], din[6]));
        hit_f = din[8];
        hit_v = din[7];
        hit_h = din[6];
    end

    // A hit needs a zero word before it, so two hits never touch.
    assert_no_adjacent_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/trs_flywheel.sv
// Line position flywheel. Counts word positions within a line and locks to
// a timing event: an external H falling edge or a detected reference
// sequence. Once locked it free-runs and tolerates MISS_LIMIT consecutive
// misses before dropping lock. Assumes SAV_POS + 4 < LINE_LEN.
module trs_flywheel #(
    parameter int LINE_LEN   = 32,
    parameter int SAV_POS    = 12,
    parameter int MISS_LIMIT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        use_embedded,
    input  logic                        h_mode,
    input  logic                        h_in,
    input  logic                        emb_hit,
    input  logic                        emb_h,
    output logic [$clog2(LINE_LEN)-1:0] pos,
    output logic                        locked
);
    localparam int POS_W  = $clog2(LINE_LEN);
    localparam int MISS_W = $clog2(MISS_LIMIT + 2);
    localparam logic [POS_W-1:0]  LAST       = POS_W'(LINE_LEN - 1);
    localparam logic [POS_W-1:0]  EAV_XYZ    = POS_W'(TRS_FLAG_OFS);
    localparam logic [POS_W-1:0]  SAV_XYZ    = POS_W'(SAV_POS + TRS_FLAG_OFS);
    localparam logic [POS_W-1:0]  EDGE_BLANK = POS_W'(SAV_POS + 4);
    localparam logic [POS_W-1:0]  EDGE_TRS   = POS_W'(SAV_POS);
    localparam logic [MISS_W-1:0] MISS_MAX   = MISS_W'(MISS_LIMIT);
    localparam int TRS_FLAG_OFS = 3;

    logic              h_prev;
    logic [MISS_W-1:0] miss_cnt;
    logic              event_seen, event_due, on_time, slip;
    logic [POS_W-1:0]  event_pos, h_ref, pos_inc, pos_resync;

    // Selects the timing event and judges it against the predicted position.
    always_comb begin
        h_ref      = h_mode ? EDGE_TRS : EDGE_BLANK;
        event_seen = use_embedded ? emb_hit : (h_prev & ~h_in);
        event_pos  = use_embedded ? (emb_h ? EAV_XYZ : SAV_XYZ) : h_ref;
        event_due  = use_embedded ? ((pos == EAV_XYZ) || (pos == SAV_XYZ)) : (pos == h_ref);
        on_time    = event_seen && (event_pos == pos);
        slip       = (event_seen && !on_time) || (event_due && !event_seen);
        pos_inc    = (pos == LAST) ? '0 : pos + 1'b1;
        pos_resync = (event_pos == LAST) ? '0 : event_pos + 1'b1;
    end

    // Remembers the previous external H level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) h_prev <= 1'b0;
        else        h_prev <= h_in;
    end

    // Advances the position, acquires lock and counts consecutive misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            locked   <= 1'b0;
            miss_cnt <= '0;
        end else if (!locked) begin
            miss_cnt <= '0;
            if (event_seen) begin
                pos    <= pos_resync;
                locked <= 1'b1;
            end else begin
                pos    <= pos_inc;
            end
        end else begin
            pos <= pos_inc;
            if (slip) begin
                if (miss_cnt == MISS_MAX) begin
                    locked   <= 1'b0;
                    miss_cnt <= '0;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                end
            end else if (on_time) begin
                miss_cnt <= '0;
            end
        end
    end

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    assert_miss_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= MISS_MAX);
    assert_drop_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(miss_cnt) == MISS_MAX));
    assert_event_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && event_seen) |=> locked);
endmodule

// File: rtl/trs_word_mux.sv
// Output word selection and register. Decodes the reference slots from the
// flywheel position, inserts reference words, applies blanking levels and
// registers the result. Assumes SAV_POS is even and SAV_POS + 4 < LINE_LEN.
module trs_word_mux
    import trs_fly_pkg::*;
#(
    parameter int LINE_LEN = 32,
    parameter int SAV_POS  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  word_t                       din,
    input  logic [$clog2(LINE_LEN)-1:0] pos,
    input  logic                        locked,
    input  logic                        ins_en,
    input  logic                        blank_n,
    input  logic                        f_bit,
    input  logic                        v_bit,
    output word_t                       dout
);
    localparam int POS_W = $clog2(LINE_LEN);
    localparam int N_TRS = 2;

    logic [N_TRS-1:0] in_trs;
    logic [1:0]       sub_w [N_TRS];
    logic             in_slot;
    logic [1:0]       sub;
    word_t            trs_val, next_word;

    // One slot decoder per reference sequence in the line.
    for (genvar g = 0; g < N_TRS; g++) begin : g_slot
        localparam logic [POS_W-1:0] BASE = POS_W'(g == 0 ? 0 : SAV_POS);
        logic [POS_W-1:0] rel;
        assign rel       = pos - BASE;
        assign in_trs[g] = (rel < POS_W'(TRS_LEN));
        assign sub_w[g]  = rel[1:0];
    end

    // Picks the reference word for the current slot offset.
    always_comb begin
        in_slot = |in_trs;
        sub     = in_trs[0] ? sub_w[0] : sub_w[1];
        case (sub)
            2'd0:    trs_val = WORD_ONES;
            2'd3:    trs_val = xyz_word(f_bit, v_bit, in_trs[0]);
            default: trs_val = WORD_ZERO;
        endcase
    end

    // Chooses between inserted, blanked and passed-through words.
    always_comb begin
        if (locked && in_slot) begin
            next_word = ins_en ? trs_val : din;
        end else if (locked && !blank_n) begin
            next_word = pos[0] ? BLANK_Y : BLANK_C;
        end else begin
            next_word = din;
        end
    end

    // Registers the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= next_word;
    end

    assert_blank_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !blank_n && !in_slot) |=> ((dout == BLANK_Y) || (dout == BLANK_C)));
    assert_slot_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ins_en && in_slot && (sub == 2'd0)) |=> (dout == WORD_ONES));
    assert_one_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_trs));
endmodule

// File: rtl/trs_flywheel_inserter.sv
// Top level of the timing reference flywheel and inserter. Selects the
// timing source, keeps the field and vertical flags of the last detected
// sequence, and gates insertion by the global enable and feature disable.
// Output latency is one clock. Assumes SAV_POS even, SAV_POS + 4 < LINE_LEN.
module trs_flywheel_inserter
    import trs_fly_pkg::*;
#(
    parameter int LINE_LEN   = 32,
    parameter int SAV_POS    = 12,
    parameter int MISS_LIMIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_embedded,
    input  logic        h_mode,
    input  logic        h_in,
    input  logic        v_in,
    input  logic        f_in,
    input  logic        proc_en,
    input  logic        trs_off,
    input  logic        blank_n,
    input  logic [9:0]  din,
    output logic [9:0]  dout
);
    localparam int POS_W = $clog2(LINE_LEN);

    logic             hit, hit_f, hit_v, hit_h;
    logic [POS_W-1:0] pos;
    logic             locked;
    logic             f_q, v_q;
    logic             f_bit, v_bit, ins_en;

    trs_embedded_detect i_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .hit   (hit),
        .hit_f (hit_f),
        .hit_v (hit_v),
        .hit_h (hit_h)
    );

    trs_flywheel #(
        .LINE_LEN   (LINE_LEN),
        .SAV_POS    (SAV_POS),
        .MISS_LIMIT (MISS_LIMIT)
    ) i_flywheel (
        .clk          (clk),
        .rst_n        (rst_n),
        .use_embedded (src_embedded),
        .h_mode       (h_mode),
        .h_in         (h_in),
        .emb_hit      (hit),
        .emb_h        (hit_h),
        .pos          (pos),
        .locked       (locked)
    );

    // Holds F and V from the latest detected sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= 1'b0;
            v_q <= 1'b0;
        end else if (hit) begin
            f_q <= hit_f;
            v_q <= hit_v;
        end
    end

    // Chooses the flag source and the insertion gate.
    always_comb begin
        f_bit  = src_embedded ? (hit ? hit_f : f_q) : f_in;
        v_bit  = src_embedded ? (hit ? hit_v : v_q) : v_in;
        ins_en = proc_en & ~trs_off;
    end

    trs_word_mux #(
        .LINE_LEN (LINE_LEN),
        .SAV_POS  (SAV_POS)
    ) i_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .pos     (pos),
        .locked  (locked),
        .ins_en  (ins_en),
        .blank_n (blank_n),
        .f_bit   (f_bit),
        .v_bit   (v_bit),
        .dout    (dout)
    );

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && (!proc_en || trs_off)) |=> (dout == $past(din)));
    assert_unlocked_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (dout == $past(din)));
endmodule

// File: tb/test_trs_flywheel_inserter.sv
module test_trs_flywheel_inserter;
    localparam int LINE_LEN   = 32;
    localparam int SAV_POS    = 12;
    localparam int MISS_LIMIT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_embedded = 1'b0, h_mode = 1'b0, h_in = 1'b0, v_in = 1'b0, f_in = 1'b0;
    logic       proc_en = 1'b0, trs_off = 1'b0, blank_n = 1'b1;
    logic [9:0] din = '0;
    logic [9:0] dout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // control values applied together with the next driven word
    bit c_emb = 0, c_hcfg = 0, c_proc = 1, c_off = 0, c_blank_n = 1;

    // pending check for the word driven at the previous negedge
    logic [9:0] pend_exp = '0;
    bit         pend_v = 0;
    string      pend_tag = "";

    // bench model of the requirements
    bit m_lock = 0;
    int m_miss = 0;
    int m_f = 0, m_v = 0;

    always #10 clk = ~clk;   // 50 MHz

    trs_flywheel_inserter #(
        .LINE_LEN(LINE_LEN), .SAV_POS(SAV_POS), .MISS_LIMIT(MISS_LIMIT)
    ) i_trs_flywheel_inserter (
        .clk(clk), .rst_n(rst_n), .src_embedded(src_embedded), .h_mode(h_mode),
        .h_in(h_in), .v_in(v_in), .f_in(f_in), .proc_en(proc_en), .trs_off(trs_off),
        .blank_n(blank_n), .din(din), .dout(dout)
    );

    function automatic logic [9:0] model_xyz(int f, int v, int h);
        int s;
        s = 512 + 256 * f + 128 * v + 64 * h + 32 * (v ^ h) + 16 * (f ^ h) + 8 * (f ^ v) + 4 * (f ^ v ^ h);
        return 10'(s);
    endfunction

    task automatic step(input logic [9:0] d, input bit h, input bit v, input bit f,
                        input logic [9:0] e, input bit chk, input string tag);
        @(negedge clk);
        if (pend_v) begin
            checks++;
            if (dout !== pend_exp) begin
                errors++;
                $display("FAIL %s: dout=%h expected %h", pend_tag, dout, pend_exp);
            end
        end
        din = d; h_in = h; v_in = v; f_in = f;
        src_embedded = c_emb; h_mode = c_hcfg; proc_en = c_proc; trs_off = c_off; blank_n = c_blank_n;
        pend_exp = e; pend_v = chk; pend_tag = tag;
    endtask

    task automatic do_reset();
        step(10'h000, 0, 0, 0, 10'h000, 0, "");
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (dout !== 10'h000) begin
            errors++;
            $display("FAIL R1 reset: dout=%h expected 000", dout);
        end
        rst_n = 1'b1;
        m_lock = 0; m_miss = 0; m_f = 0; m_v = 0;
    endtask

    // kind: 0 absent, 1 valid, 2 corrupted protection (embedded input only)
    task automatic run_line(input int line, input int f, input int v,
                            input int eav_kind, input int sav_kind, input string tag);
        for (int p = 0; p < LINE_LEN; p++) begin
            logic [9:0] d, e;
            int is_eav, slot, sub, kind, hd, vd, fd, ef, ev, sync;
            d      = 10'(256 + ((line * 29 + p * 37) % 256));
            is_eav = (p < 4) ? 1 : 0;
            slot   = (is_eav == 1 || (p >= SAV_POS && p < SAV_POS + 4)) ? 1 : 0;
            sub    = (is_eav == 1) ? p : p - SAV_POS;
            kind   = (is_eav == 1) ? eav_kind : sav_kind;
            if (c_emb && slot == 1 && kind != 0) begin
                case (sub)
                    0:       d = 10'h3FF;
                    3:       d = model_xyz(f, v, is_eav) ^ ((kind == 2) ? 10'h004 : 10'h000);
                    default: d = 10'h000;
                endcase
            end
            if (c_emb) begin
                hd = p % 2; vd = (p % 3 == 0) ? 1 : 0; fd = (p % 5 == 0) ? 1 : 0;
                sync = (slot == 1 && sub == 3 && kind == 1) ? 1 : 0;
            end else begin
                hd = c_hcfg ? ((p < SAV_POS) ? 1 : 0) : ((p < SAV_POS + 4) ? 1 : 0);
                vd = v; fd = f;
                sync = (p == (c_hcfg ? SAV_POS : SAV_POS + 4)) ? 1 : 0;
            end
            if (!c_emb || (slot == 1 && sub == 3 && kind == 1)) begin
                ef = f; ev = v;
            end else begin
                ef = m_f; ev = m_v;
            end
            e = d;
            if (m_lock) begin
                if (slot == 1) begin
                    if (c_proc && !c_off) begin
                        case (sub)
                            0:       e = 10'h3FF;
                            3:       e = model_xyz(ef, ev, is_eav);
                            default: e = 10'h000;
                        endcase
                    end
                end else if (!c_blank_n) begin
                    e = (p % 2 == 1) ? 10'h040 : 10'h200;
                end
            end
            step(d, hd[0], vd[0], fd[0], e, 1, $sformatf("%s line %0d pos %0d", tag, line, p));
            // model update after the word
            if (c_emb && slot == 1 && sub == 3 && kind == 1) begin
                m_f = f; m_v = v;
            end
            if (!m_lock) begin
                if (sync == 1) begin
                    m_lock = 1; m_miss = 0;
                end
            end else if (c_emb && slot == 1 && sub == 3) begin
                if (kind == 1) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss > MISS_LIMIT) begin
                        m_lock = 0; m_miss = 0;
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R10: run still active, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state, then external timing with blanking-wide H (R2, R4, R5)
        c_emb = 0; c_hcfg = 0; c_proc = 1; c_off = 0; c_blank_n = 1;
        do_reset();
        for (int l = 0; l < 5; l++)
            run_line(l, (l / 2) % 2, l % 2, 0, 0, "R2 R4 R5 R10 ext h_mode0");

        // H following the reference flag (R3)
        c_hcfg = 1;
        do_reset();
        for (int l = 0; l < 4; l++)
            run_line(l + 10, l % 2, (l / 2) % 2, 0, 0, "R3 R4 R5 ext h_mode1");

        // gating (R8)
        c_off = 1;
        run_line(20, 1, 0, 0, 0, "R8 feature disabled");
        c_off = 0; c_proc = 0;
        run_line(21, 0, 1, 0, 0, "R8 global off");
        c_off = 1;
        run_line(22, 1, 1, 0, 0, "R8 both off");
        c_off = 0; c_proc = 1;
        run_line(23, 0, 0, 0, 0, "R8 restored");

        // blanking (R9)
        c_blank_n = 0;
        run_line(24, 1, 1, 0, 0, "R9 blank with insertion");
        c_off = 1;
        run_line(25, 0, 1, 0, 0, "R9 blank without insertion");
        c_off = 0; c_blank_n = 1;
        run_line(26, 1, 0, 0, 0, "R10 blank released");

        // embedded timing (R6, R7), external V/F toggled and ignored
        c_emb = 1; c_hcfg = 0;
        do_reset();
        run_line(30, 0, 1, 1, 1, "R6 embedded lock");
        run_line(31, 1, 0, 1, 1, "R6 embedded flags");
        run_line(32, 0, 0, 0, 0, "R7 two missing kept");
        run_line(33, 1, 1, 1, 1, "R6 R7 recovered");
        run_line(34, 0, 0, 2, 1, "R7 corrupted kept");
        run_line(35, 0, 1, 1, 0, "R7 one miss");
        run_line(36, 1, 0, 0, 0, "R7 lock dropped");
        run_line(37, 1, 1, 0, 0, "R7 no insertion unlocked");
        run_line(38, 1, 0, 1, 1, "R6 relock");
        run_line(39, 0, 1, 1, 1, "R6 relocked");
        step(10'h000, 0, 0, 0, 10'h000, 0, "");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule